// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks of a processor-style device are running. In run mode the CPU, every peripheral and the oscillator/PLL are all enabled. When the CPU wants to save power, it presents a mode code and pulses an enter strobe. The controller then moves to one of three sleep levels: idle, standby or halt. Each deeper level switches off more clocks and accepts fewer events as a reason to wake.

In idle, only the CPU clock stops. Peripherals flagged as keep-alive at the moment of entry keep their clocks, and an enabled peripheral interrupt ends the sleep. In standby, the CPU and all peripherals stop while the oscillator keeps running, and an external interrupt wakes the device on the next cycle. In halt, the oscillator stops as well, and only the non-maskable interrupt or reset can bring the device back. Leaving halt first turns the oscillator on. A modelled settling interval must then expire before any other clock returns.

Every return to run mode is marked by a one-cycle wake pulse. Reset, from any state, puts the block back in run mode with every clock enabled.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: The mode code is 2 bits: 00 = run, 01 = idle, 10 = standby, 11 = halt. In run mode, an enter strobe seen at a clock edge with code 01, 10 or 11 moves the block to that mode, and its outputs show the new mode right after that edge. A strobe with code 00 changes nothing.
- R2: In idle, cpu_clk_en is 0 and osc_en is 1. Bit i of periph_clk_en equals bit i of the keep-alive input as sampled on the entry strobe.
- R3: Idle ends on the clock edge where periph_irq or nmi is high. A high ext_irq has no effect in idle.
- R4: In standby, cpu_clk_en and every periph_clk_en bit are 0 and osc_en is 1. Standby ends on the edge where ext_irq or nmi is high; periph_irq has no effect there.
- R5: In halt, cpu_clk_en, every periph_clk_en bit and osc_en are all 0. Neither periph_irq nor ext_irq has any effect in halt.
- R6: The edge that sees nmi in halt sets osc_en to 1 while the CPU and peripheral enables stay 0. They return to 1 exactly STAB_CYCLES edges later.
- R7: In run mode, cpu_clk_en, osc_en and every periph_clk_en bit are 1. wake_pulse is 1 for exactly the first cycle of every return to run from a low-power mode, and is 0 otherwise.
- R8: An active-low reset acts at once, from any state. It forces run mode with all enables at 1 and wake_pulse at 0.
- R9: An enter strobe seen while the block is not in run mode is ignored.
- R10: A change of the keep-alive input while in idle leaves periph_clk_en unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 2 | Requested mode code (00 run, 01 idle, 10 standby, 11 halt) |
| enter_stb | input | 1 | Single-cycle strobe that requests entry into mode_req |
| keep_alive | input | NUM_PERIPH | Peripherals that keep their clock during idle |
| periph_irq | input | 1 | An enabled interrupt from an active peripheral is pending |
| ext_irq | input | 1 | External interrupt event detected |
| nmi | input | 1 | Non-maskable interrupt |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| osc_en | output | 1 | Oscillator and PLL enable |
| wake_pulse | output | 1 | One-cycle marker of a return to run mode |

## Verification
Every enable is decoded from a single state register, so a mode change or a wake event shows at the outputs one edge after it is presented, and a halt exit shows osc_en one edge after nmi and the other clocks STAB_CYCLES edges after that. The bench drives stimulus on falling edges and checks each result on the next falling edge. For the settling interval it counts edges explicitly and checks every intermediate cycle as well as the one where the clocks come back. The reset checks sample a short delay after the reset input falls, with no clock edge in between, to show that the reset does not wait for the clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   localparam logic [1:0] MODE_RUN     = 2'b00;
   localparam logic [1:0] MODE_IDLE    = 2'b01;
   localparam logic [1:0] MODE_STANDBY = 2'b10;
   localparam logic [1:0] MODE_HALT    = 2'b11;

   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_IDLE    = 3'd1,
      ST_STANDBY = 3'd2,
      ST_HALT    = 3'd3,
      ST_SETTLE  = 3'd4
   } lpm_state_e;
endpackage

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
   parameter int STAB_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic done
);
   localparam int CW = (STAB_CYCLES < 2) ? 1 : $clog2(STAB_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (STAB_CYCLES == 1) begin : g_single
         // one settling cycle: no counter needed
         assign done = active;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= '0;
         end
      end else begin : g_count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (!active) cnt_q <= '0;
            else              cnt_q <= cnt_q + CW'(1);
         end
         assign done = active && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_pkg::*;
#(
   parameter int NUM_PERIPH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_req,
   input  logic                  enter_stb,
   input  logic [NUM_PERIPH-1:0] keep_alive,
   input  logic                  periph_irq,
   input  logic                  ext_irq,
   input  logic                  nmi,
   input  logic                  settle_done,
   output lpm_state_e            state_q,
   output logic [NUM_PERIPH-1:0] keep_q,
   output logic                  wake_q
);
   lpm_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (enter_stb) begin
               unique case (mode_req)
                  MODE_IDLE:    state_d = ST_IDLE;
                  MODE_STANDBY: state_d = ST_STANDBY;
                  MODE_HALT:    state_d = ST_HALT;
                  default:      state_d = ST_RUN;
               endcase
            end
         end
         ST_IDLE:    if (periph_irq || nmi) state_d = ST_RUN;
         ST_STANDBY: if (ext_irq || nmi)    state_d = ST_RUN;
         ST_HALT:    if (nmi)               state_d = ST_SETTLE;
         ST_SETTLE:  if (settle_done)       state_d = ST_RUN;
         default:                           state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         keep_q  <= '0;
         wake_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         wake_q  <= (state_q != ST_RUN) && (state_d == ST_RUN);
         if (state_q == ST_RUN && enter_stb && mode_req == MODE_IDLE)
            keep_q <= keep_alive;
      end
   end
endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
   import lpm_pkg::*;
#(
   parameter int NUM_PERIPH = 4
) (
   input  lpm_state_e            state_q,
   input  logic [NUM_PERIPH-1:0] keep_q,
   output logic                  cpu_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  osc_en
);
   logic in_run;
   logic in_idle;

   assign in_run     = (state_q == ST_RUN);
   assign in_idle    = (state_q == ST_IDLE);
   assign cpu_clk_en = in_run;
   assign osc_en     = (state_q != ST_HALT);

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
         assign periph_clk_en[i] = in_run || (in_idle && keep_q[i]);
      end
   endgenerate
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
   import lpm_pkg::*;
#(
   parameter int NUM_PERIPH  = 4,
   parameter int STAB_CYCLES = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_req,
   input  logic                  enter_stb,
   input  logic [NUM_PERIPH-1:0] keep_alive,
   input  logic                  periph_irq,
   input  logic                  ext_irq,
   input  logic                  nmi,
   output logic                  cpu_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  osc_en,
   output logic                  wake_pulse
);
   generate
      if (NUM_PERIPH < 1) begin : g_bad_np
         $error("lpm_clk_ctrl: NUM_PERIPH must be at least 1");
      end
      if (STAB_CYCLES < 1) begin : g_bad_stab
         $error("lpm_clk_ctrl: STAB_CYCLES must be at least 1");
      end
   endgenerate

   lpm_state_e            state_q;
   logic [NUM_PERIPH-1:0] keep_q;
   logic                  settle_done;

   lpm_mode_fsm #(.NUM_PERIPH(NUM_PERIPH)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_req    (mode_req),
      .enter_stb   (enter_stb),
      .keep_alive  (keep_alive),
      .periph_irq  (periph_irq),
      .ext_irq     (ext_irq),
      .nmi         (nmi),
      .settle_done (settle_done),
      .state_q     (state_q),
      .keep_q      (keep_q),
      .wake_q      (wake_pulse)
   );

   lpm_settle_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state_q == ST_SETTLE),
      .done   (settle_done)
   );

   lpm_clk_decode #(.NUM_PERIPH(NUM_PERIPH)) u_dec (
      .state_q       (state_q),
      .keep_q        (keep_q),
      .cpu_clk_en    (cpu_clk_en),
      .periph_clk_en (periph_clk_en),
      .osc_en        (osc_en)
   );
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk
   import lpm_pkg::*;
#(
   parameter int NUM_PERIPH = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input lpm_state_e            state_q,
   input logic                  periph_irq,
   input logic                  ext_irq,
   input logic                  nmi,
   input logic                  cpu_clk_en,
   input logic [NUM_PERIPH-1:0] periph_clk_en,
   input logic                  osc_en,
   input logic                  wake_pulse
);
   p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   p_wake_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (cpu_clk_en && osc_en && (&periph_clk_en)));

   p_cpu_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_clk_en) |-> wake_pulse);

   p_run_all_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_en |-> (osc_en && (&periph_clk_en)));

   p_osc_off_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (!cpu_clk_en && (periph_clk_en == '0)));

   p_halt_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && nmi) |=> (osc_en && !cpu_clk_en && (periph_clk_en == '0)));

   p_osc_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en) |-> !cpu_clk_en);

   p_halt_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && !nmi) |=> !osc_en);

   p_standby_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STANDBY && !ext_irq && !nmi) |=> (osc_en && !cpu_clk_en && (periph_clk_en == '0)));

   p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && (periph_irq || nmi)) |=> (cpu_clk_en && wake_pulse));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .state_q       (state_q),
   .periph_irq    (periph_irq),
   .ext_irq       (ext_irq),
   .nmi           (nmi),
   .cpu_clk_en    (cpu_clk_en),
   .periph_clk_en (periph_clk_en),
   .osc_en        (osc_en),
   .wake_pulse    (wake_pulse)
);

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NP         = 4;
   localparam int SC         = 5;
   localparam logic [NP-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_req = 2'b00;
   logic          enter_stb = 1'b0;
   logic [NP-1:0] keep_alive = '0;
   logic          periph_irq = 1'b0;
   logic          ext_irq = 1'b0;
   logic          nmi = 1'b0;
   logic          cpu_clk_en;
   logic [NP-1:0] periph_clk_en;
   logic          osc_en;
   logic          wake_pulse;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpm_clk_ctrl #(.NUM_PERIPH(NP), .STAB_CYCLES(SC)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .enter_stb(enter_stb),
      .keep_alive(keep_alive), .periph_irq(periph_irq), .ext_irq(ext_irq), .nmi(nmi),
      .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
      .wake_pulse(wake_pulse)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   // expected vector = {wake, osc, cpu, periph}
   task automatic expect_out(input string req, input logic w, input logic o,
                             input logic c, input logic [NP-1:0] p);
      logic [NP+2:0] act, exp;
      act = {wake_pulse, osc_en, cpu_clk_en, periph_clk_en};
      exp = {w, o, c, p};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (wake,osc,cpu,periph)", req, act, exp);
      end
   endtask

   task automatic enter(input logic [1:0] m, input logic [NP-1:0] mask);
      keep_alive = mask;
      mode_req   = m;
      enter_stb  = 1'b1;
      tick();
      enter_stb  = 1'b0;
      mode_req   = 2'b00;
   endtask

   // src: 0 periph_irq, 1 ext_irq, 2 nmi
   task automatic pulse_src(input int src);
      periph_irq = (src == 0);
      ext_irq    = (src == 1);
      nmi        = (src == 2);
      tick();
      periph_irq = 1'b0;
      ext_irq    = 1'b0;
      nmi        = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      #(CLK_PERIOD/4);
      expect_out("R8 in reset", 1'b0, 1'b1, 1'b1, ALL);
      tick(); tick();
      rst_n = 1'b1;
      tick();
      expect_out("R7 run after reset", 1'b0, 1'b1, 1'b1, ALL);

      // R1: code 00 strobe has no effect
      enter(2'b00, 4'h3);
      expect_out("R1 code 00 ignored", 1'b0, 1'b1, 1'b1, ALL);

      // Idle sweep over every keep mask and both wake sources
      for (int mask = 0; mask < (1 << NP); mask++) begin
         for (int w = 0; w < 2; w++) begin
            enter(2'b01, NP'(mask));
            expect_out("R2 idle entry", 1'b0, 1'b1, 1'b0, NP'(mask));
            keep_alive = ~NP'(mask);
            tick();
            expect_out("R10 keep change ignored", 1'b0, 1'b1, 1'b0, NP'(mask));
            pulse_src(1);
            expect_out("R3 ext_irq ignored in idle", 1'b0, 1'b1, 1'b0, NP'(mask));
            enter(2'b11, '0);
            expect_out("R9 strobe ignored in idle", 1'b0, 1'b1, 1'b0, NP'(mask));
            pulse_src(w == 0 ? 0 : 2);
            expect_out("R3 idle wake", 1'b1, 1'b1, 1'b1, ALL);
            tick();
            expect_out("R7 wake one cycle", 1'b0, 1'b1, 1'b1, ALL);
         end
      end

      // Standby with both wake sources
      for (int w = 0; w < 2; w++) begin
         enter(2'b10, ALL);
         expect_out("R4 standby entry", 1'b0, 1'b1, 1'b0, '0);
         pulse_src(0);
         expect_out("R4 periph_irq ignored", 1'b0, 1'b1, 1'b0, '0);
         enter(2'b01, ALL);
         expect_out("R9 strobe ignored in standby", 1'b0, 1'b1, 1'b0, '0);
         pulse_src(w == 0 ? 1 : 2);
         expect_out("R4 standby wake", 1'b1, 1'b1, 1'b1, ALL);
         tick();
         expect_out("R7 wake one cycle", 1'b0, 1'b1, 1'b1, ALL);
      end

      // Halt and settling interval
      enter(2'b11, ALL);
      expect_out("R5 halt entry", 1'b0, 1'b0, 1'b0, '0);
      pulse_src(0);
      expect_out("R5 periph_irq ignored", 1'b0, 1'b0, 1'b0, '0);
      pulse_src(1);
      expect_out("R5 ext_irq ignored", 1'b0, 1'b0, 1'b0, '0);
      enter(2'b01, ALL);
      expect_out("R9 strobe ignored in halt", 1'b0, 1'b0, 1'b0, '0);
      pulse_src(2);
      expect_out("R6 osc first", 1'b0, 1'b1, 1'b0, '0);
      for (int k = 1; k < SC; k++) begin
         pulse_src(0);
         expect_out("R6 settling", 1'b0, 1'b1, 1'b0, '0);
      end
      tick();
      expect_out("R6 clocks back", 1'b1, 1'b1, 1'b1, ALL);
      tick();
      expect_out("R7 wake one cycle", 1'b0, 1'b1, 1'b1, ALL);

      // R8: asynchronous reset from halt, settling and idle
      for (int s = 0; s < 3; s++) begin
         enter(s == 2 ? 2'b01 : 2'b11, 4'h5);
         if (s == 1) begin
            pulse_src(2);
            tick();
         end
         #(CLK_PERIOD/4);
         rst_n = 1'b0;
         #1;
         expect_out("R8 async reset", 1'b0, 1'b1, 1'b1, ALL);
         tick();
         rst_n = 1'b1;
         tick();
         expect_out("R8 run after reset", 1'b0, 1'b1, 1'b1, ALL);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule